// File: doc/BRIEF.md
# Triple Frame Buffer Manager

This block sits between a video capture stream and a display fetch path and hands out external-memory addresses for both. The write side watches a pixel stream with a frame sync and an active-data flag. Only active samples produce a write strobe, and blanking samples are dropped. Writes fill one of three frame slots, and the slots are used as a ring. When the last active pixel of a frame has been written, the writer raises a one-cycle completion pulse and moves on to the next slot.

The read side answers pixel requests from the display. At the first pixel of each read frame it takes the slot that was completed most recently. It keeps that slot until its own frame ends, so it always trails the writer by one whole frame and never starts on the slot that is being filled. If the writer has not finished a new frame by then, the reader shows the same slot again. Until the first frame has been completed, the reader reports that it has no picture and ignores requests.

Each address is the slot base plus the raster offset of the pixel. The slot base is the slot number times the frame size, and the raster offset is line times width plus column. The memory controller is not part of this block.

Top module: `triple_fb_mgr`

## Requirements
- R1: After reset, wr_en, rd_en, rd_sof and frame_done are low, rd_blank is high, and wr_slot and rd_slot are 0.
- R2: A write strobe is produced only for a cycle with in_de high and in_vs low. wr_en rises on the next clock edge, and wr_data carries the pixel that was sampled with it.
- R3: wr_addr equals wr_slot*H_ACT*V_ACT + line*H_ACT + col, where line and col are the raster position given by the count of active pixels since the frame start.
- R4: The write of the H_ACT*V_ACT-th active pixel carries a one-cycle frame_done pulse, and on that edge wr_slot advances in the ring order 0, 1, 2, 0.
- R5: A cycle with in_vs high takes priority over in_de. It moves the write position back to line 0, column 0 of the same slot, and produces no frame_done and no write.
- R6: While no frame has been completed since reset, rd_blank is high and rd_req is ignored, so no rd_en is produced.
- R7: Once a frame has been completed, rd_req produces rd_en on the next edge. rd_addr equals rd_slot*H_ACT*V_ACT plus a raster offset that steps through the frame in order and wraps to 0 after the last pixel.
- R8: rd_sof marks the first read of each read frame. The rd_slot shown with it is the slot of the most recent frame_done seen before that request edge, and that slot differs from wr_slot.
- R9: If no frame completes during a read frame, the next read frame reads the same slot again.
- R10: A completion that arrives in the middle of a read frame does not change rd_slot until the next rd_sof.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vs | input | 1 | Frame start; sends the write position back to the start of the frame |
| in_de | input | 1 | High when the incoming sample is active video |
| in_pix | input | PIX_W | Incoming pixel sample |
| wr_en | output | 1 | Memory write strobe |
| wr_addr | output | AW | Memory write address |
| wr_data | output | PIX_W | Pixel to write |
| wr_slot | output | SW | Slot currently being written |
| frame_done | output | 1 | One-cycle pulse when a frame has been completely written |
| rd_req | input | 1 | Display asks for the next pixel |
| rd_en | output | 1 | Memory read strobe |
| rd_addr | output | AW | Memory read address |
| rd_sof | output | 1 | Marks the first read of a read frame |
| rd_slot | output | SW | Slot currently being read |
| rd_blank | output | 1 | No completed frame is available yet |

## Verification
The hardest case to reach is a read frame that starts on the same edge as a write completion, or a completion that lands in the middle of a read frame. For that, the reader has to be much slower than the writer over several frames. The stimulus uses a small frame size and runs a phase in which the write stream is continuous while rd_req is high only now and then, so completions fall at many different points of the read frame. Another phase stops the writer completely while the reader keeps going, which forces the same slot to be read again.

// File: rtl/triple_fb_mgr.sv
module triple_fb_mgr #(
  parameter int H_ACT = 742,
  parameter int V_ACT = 480,
  parameter int PIX_W = 10,
  parameter int NSLOT = 3,
  localparam int FRAME = H_ACT * V_ACT,
  localparam int OW = $clog2(FRAME + 1),
  localparam int AW = $clog2(NSLOT * FRAME + 1),
  localparam int SW = $clog2(NSLOT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vs,
  input  logic             in_de,
  input  logic [PIX_W-1:0] in_pix,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [PIX_W-1:0] wr_data,
  output logic [SW-1:0]    wr_slot,
  output logic             frame_done,
  input  logic             rd_req,
  output logic             rd_en,
  output logic [AW-1:0]    rd_addr,
  output logic             rd_sof,
  output logic [SW-1:0]    rd_slot,
  output logic             rd_blank
);

  logic [OW-1:0] w_ofs, r_ofs;
  logic [SW-1:0] pend_q;
  logic          have_q;

  function automatic logic [AW-1:0] slot_base(input logic [SW-1:0] s);
    return AW'(s) * AW'(FRAME);
  endfunction

  function automatic logic [SW-1:0] slot_next(input logic [SW-1:0] s);
    return (s == SW'(NSLOT - 1)) ? '0 : s + SW'(1);
  endfunction

  wire w_take = in_de & ~in_vs;
  wire w_last = w_take && (w_ofs == OW'(FRAME - 1));
  wire r_go   = rd_req & have_q;
  wire r_first = (r_ofs == '0);
  wire r_last  = (r_ofs == OW'(FRAME - 1));
  wire [SW-1:0] r_use = r_first ? pend_q : rd_slot;

  assign rd_blank = ~have_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_en      <= 1'b0;
      wr_addr    <= '0;
      wr_data    <= '0;
      wr_slot    <= '0;
      frame_done <= 1'b0;
      w_ofs      <= '0;
      pend_q     <= '0;
      have_q     <= 1'b0;
    end else begin
      wr_en      <= w_take;
      frame_done <= w_last;
      if (w_take) begin
        wr_addr <= slot_base(wr_slot) + AW'(w_ofs);
        wr_data <= in_pix;
      end
      if (in_vs) begin
        w_ofs <= '0;
      end else if (w_last) begin
        w_ofs   <= '0;
        wr_slot <= slot_next(wr_slot);
        pend_q  <= wr_slot;
        have_q  <= 1'b1;
      end else if (w_take) begin
        w_ofs <= w_ofs + OW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_en   <= 1'b0;
      rd_sof  <= 1'b0;
      rd_addr <= '0;
      rd_slot <= '0;
      r_ofs   <= '0;
    end else begin
      rd_en  <= r_go;
      rd_sof <= r_go & r_first;
      if (r_go) begin
        rd_slot <= r_use;
        rd_addr <= slot_base(r_use) + AW'(r_ofs);
        r_ofs   <= r_last ? '0 : r_ofs + OW'(1);
      end
    end
  end

endmodule

module triple_fb_mgr_chk #(
  parameter int H_ACT = 742,
  parameter int V_ACT = 480,
  parameter int PIX_W = 10,
  parameter int NSLOT = 3,
  localparam int FRAME = H_ACT * V_ACT,
  localparam int AW = $clog2(NSLOT * FRAME + 1),
  localparam int SW = $clog2(NSLOT)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    wr_addr,
  input logic [SW-1:0]    wr_slot,
  input logic             frame_done,
  input logic             rd_en,
  input logic [AW-1:0]    rd_addr,
  input logic             rd_sof,
  input logic [SW-1:0]    rd_slot,
  input logic             rd_blank
);

  function automatic logic in_slot(input logic [AW-1:0] a, input logic [SW-1:0] s);
    return (a >= AW'(s) * AW'(FRAME)) && (a < AW'(s) * AW'(FRAME) + AW'(FRAME));
  endfunction

  // R3
  wr_addr_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !frame_done |-> in_slot(wr_addr, wr_slot));

  // R4
  done_with_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> wr_en);

  // R4
  slot_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> in_slot(wr_addr, $past(wr_slot)));

  // R6
  blank_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_blank |-> !rd_en);

  // R6
  blank_falls_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_blank) |-> frame_done);

  // R7
  rd_addr_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> in_slot(rd_addr, rd_slot));

  // R8
  sof_not_writing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sof |-> rd_slot != wr_slot);

  // R10
  slot_held_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !rd_sof |-> rd_slot == $past(rd_slot));

endmodule

bind triple_fb_mgr triple_fb_mgr_chk #(
  .H_ACT(H_ACT), .V_ACT(V_ACT), .PIX_W(PIX_W), .NSLOT(NSLOT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_slot(wr_slot), .frame_done(frame_done), .rd_en(rd_en),
  .rd_addr(rd_addr), .rd_sof(rd_sof), .rd_slot(rd_slot), .rd_blank(rd_blank)
);

// File: tb/triple_fb_mgr_bench.sv
module triple_fb_mgr_bench;
  localparam int H = 4;
  localparam int V = 3;
  localparam int PW = 8;
  localparam int F = H * V;
  localparam int AW = $clog2(3 * F + 1);

  logic clk = 0, rst_n = 0;
  logic in_vs = 0, in_de = 0, rd_req = 0;
  logic [PW-1:0] in_pix = '0;
  logic wr_en, frame_done, rd_en, rd_sof, rd_blank;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [PW-1:0] wr_data;
  logic [1:0] wr_slot, rd_slot;

  int checks = 0, fails = 0, cycles = 0;

  triple_fb_mgr #(.H_ACT(H), .V_ACT(V), .PIX_W(PW), .NSLOT(3)) u_triple_fb_mgr (
    .clk(clk), .rst_n(rst_n), .in_vs(in_vs), .in_de(in_de), .in_pix(in_pix),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_slot(wr_slot),
    .frame_done(frame_done), .rd_req(rd_req), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_sof(rd_sof), .rd_slot(rd_slot), .rd_blank(rd_blank));

  always #10 clk = ~clk;

  // reference model state
  int m_wofs, m_wslot, m_pend, m_rofs, m_rslot;
  bit m_have, e_wr_en, e_fd, e_rd_en, e_sof;
  int e_wr_addr, e_wr_data, e_rd_addr;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wofs = 0; m_wslot = 0; m_pend = 0; m_rofs = 0; m_rslot = 0; m_have = 0;
      e_wr_en = 0; e_fd = 0; e_rd_en = 0; e_sof = 0;
    end else begin
      e_rd_en = 0; e_sof = 0;
      if (rd_req && m_have) begin
        e_rd_en = 1;
        if (m_rofs == 0) begin m_rslot = m_pend; e_sof = 1; end
        e_rd_addr = m_rslot * F + m_rofs;
        m_rofs = (m_rofs + 1) % F;
      end
      e_wr_en = 0; e_fd = 0;
      if (in_vs) m_wofs = 0;
      else if (in_de) begin
        e_wr_en = 1;
        e_wr_data = int'(in_pix);
        e_wr_addr = m_wslot * F + m_wofs;
        if (m_wofs == F - 1) begin
          e_fd = 1; m_pend = m_wslot; m_have = 1;
          m_wslot = (m_wslot + 1) % 3; m_wofs = 0;
        end else m_wofs++;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R10 monitor: slot constant between read frame starts
  int sof_slot = -1;
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", "wr_en", int'(wr_en), int'(e_wr_en));
      if (e_wr_en) begin
        chk("R2", "wr_data", int'(wr_data), e_wr_data);
        chk("R3", "wr_addr", int'(wr_addr), e_wr_addr);
      end
      chk("R4", "frame_done", int'(frame_done), int'(e_fd));
      chk("R4", "wr_slot", int'(wr_slot), m_wslot);
      chk("R6", "rd_blank", int'(rd_blank), int'(!m_have));
      chk("R7", "rd_en", int'(rd_en), int'(e_rd_en));
      if (e_rd_en) begin
        chk("R7", "rd_addr", int'(rd_addr), e_rd_addr);
        chk("R8", "rd_slot", int'(rd_slot), m_rslot);
      end
      chk("R8", "rd_sof", int'(rd_sof), int'(e_sof));
      if (rd_sof) begin
        chk("R8", "sof slot vs write slot", int'(rd_slot != wr_slot), 1);
        sof_slot = int'(rd_slot);
      end else if (rd_en && sof_slot >= 0)
        chk("R10", "slot held in read frame", int'(rd_slot), sof_slot);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic step(input bit vs, input bit de, input bit rq);
    @(posedge clk); #2;
    in_vs = vs; in_de = de; rd_req = rq; in_pix = PW'($urandom);
  endtask

  int first_slot;
  initial begin
    void'($urandom(7));
    repeat (3) step(0, 0, 0);
    #2 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "wr_en", int'(wr_en), 0);
    chk("R1", "rd_en", int'(rd_en), 0);
    chk("R1", "frame_done", int'(frame_done), 0);
    chk("R1", "rd_blank", int'(rd_blank), 1);
    chk("R1", "wr_slot", int'(wr_slot), 0);
    chk("R1", "rd_slot", int'(rd_slot), 0);
    // R6: requests before any frame are ignored
    repeat (10) step(0, 0, 1);
    @(negedge clk);
    chk("R6", "no read before frame", int'(rd_en), 0);
    // gapped active data, random reads
    for (int i = 0; i < 80; i++) step(0, 1'($urandom % 2), 1'($urandom % 2));
    // R5: frame restart mid-frame
    for (int i = 0; i < 5; i++) step(0, 1, 0);
    step(1, 1, 0);
    step(0, 1, 0);
    step(0, 0, 0);
    @(negedge clk);
    chk("R5", "restart at slot base", int'(wr_addr), int'(wr_slot) * F);
    // continuous stream, continuous reads
    for (int i = 0; i < 200; i++) step(0, 1, 1);
    // R9: writer idle, reader runs several frames
    step(0, 0, 0);
    @(negedge clk);
    first_slot = m_pend;
    for (int i = 0; i < 3 * F + 2; i++) begin
      step(0, 0, 1);
      @(negedge clk);
      if (rd_sof) chk("R9", "re-read same slot", int'(rd_slot), first_slot);
    end
    // R10: slow reader, fast writer
    for (int i = 0; i < 600; i++) step(0, 1'($urandom % 4 != 0), 1'($urandom % 5 == 0));
    // mixed with sync pulses
    for (int i = 0; i < 400; i++)
      step(1'($urandom % 40 == 0), 1'($urandom % 3 != 0), 1'($urandom % 2));
    step(0, 0, 0);
    step(0, 0, 0);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule